// File: doc/BRIEF.md
# Load-to-Output Latency Sync Tracker

This block follows every frequency load and every phase load of a pipelined numerically controlled oscillator on its way to the output. For each load it emits a one-clock, active-low sync pulse. The pulse marks the cycle in which the new value starts to show at the oscillator output. The two load kinds have different fixed latencies. Because loads may come as often as every fourth clock, several loads of either kind can be in flight at once. Each load is carried as its own token, so overlapping loads never merge or cancel each other.

The block also raises an output-valid flag once a short blank window after reset release has passed. It drives a buffer-bank select that flips on every frequency load, so that a ping-pong pair of frequency buffers can alternate between being written and being transferred. The load inputs are single-cycle event strobes that have already been detected upstream. They carry no data, so there is no valid/ready handshake and no back-pressure: every strobe is accepted in the cycle it is sampled. All outputs are plain control levels.

Top module: `load_sync_tracker`

## Requirements
- R1: While rst_n is low (asynchronous, active low), freq_sync_n and phase_sync_n are 1, and out_valid and bank_sel are 0.
- R2: If freq_load is 1 at rising edge k, freq_sync_n is 0 from edge k+18 until edge k+19. With no such load it stays 1.
- R3: If phase_load is 1 at rising edge k, phase_sync_n is 0 from edge k+11 until edge k+12. With no such load it stays 1.
- R4: Loads of one kind at any spacing, including consecutive cycles and every fourth cycle, each produce their own pulse at their own latency.
- R5: Frequency and phase loads are tracked independently. A load of one kind, alone or in the same cycle as the other kind, never moves or suppresses the other kind's pulse.
- R6: out_valid stays 0 through the first 5 rising edges after rst_n is released. It becomes 1 at the 6th edge and stays 1 until the next reset.
- R7: Loads sampled while out_valid is still 0 are tracked and pulse at their normal latency.
- R8: A reset discards every load in flight. No sync pulse appears after release for a load taken before the reset.
- R9: bank_sel flips at each rising edge where freq_load is 1. It holds when freq_load is 0, whatever phase_load does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_load | input | 1 | One-cycle strobe: a frequency load was taken |
| phase_load | input | 1 | One-cycle strobe: a phase load was taken |
| freq_sync_n | output | 1 | Active-low pulse: new frequency reaches the output |
| phase_sync_n | output | 1 | Active-low pulse: new phase reaches the output |
| out_valid | output | 1 | High once the post-reset blank window has elapsed |
| bank_sel | output | 1 | Ping-pong buffer bank select, flips per frequency load |

## Verification
A table of load schedules is played cycle by cycle: a lone load of each kind, frequency loads every fourth clock in ping-pong fashion, back-to-back loads of both kinds, and both kinds together at different spacings. The lone loads pin down the exact latency of each kind. The dense and back-to-back patterns show whether tokens in flight stay separate. The mixed patterns show whether the two trackers interfere, and the every-fourth-clock run shows the bank select alternating. Directed runs then check the reset state, the edge on which out_valid rises, a load taken inside the blank window, and a reset that lands while loads are still in flight.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  localparam int unsigned FREQ_LAT_DEF      = 18;
  localparam int unsigned PHASE_LAT_DEF     = 11;
  localparam int unsigned BLANK_EDGES_DEF   = 6;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/lsync_token_line.sv
module lsync_token_line #(
  parameter int unsigned LAT = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  output logic pulse_n
);
  // tok[j] holds a load sampled j edges before the latest one
  logic [LAT-1:0] tok;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok <= '0;
        else        tok <= ev_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok <= '0;
        else        tok <= {tok[LAT-2:0], ev_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_n <= 1'b1;
    else        pulse_n <= ~tok[LAT-1];
  end
endmodule

// File: rtl/lsync_blank_window.sv
module lsync_blank_window #(
  parameter int unsigned EDGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int unsigned CW = lsync_pkg::cnt_width(EDGES);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/lsync_bank_toggle.sv
module lsync_bank_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= 1'b0;
    else if (flip) bank <= ~bank;
  end
endmodule

// File: rtl/load_sync_tracker.sv
module load_sync_tracker #(
  parameter int unsigned FREQ_LAT    = lsync_pkg::FREQ_LAT_DEF,
  parameter int unsigned PHASE_LAT   = lsync_pkg::PHASE_LAT_DEF,
  parameter int unsigned BLANK_EDGES = lsync_pkg::BLANK_EDGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freq_load,
  input  logic phase_load,
  output logic freq_sync_n,
  output logic phase_sync_n,
  output logic out_valid,
  output logic bank_sel
);
  lsync_token_line #(.LAT(FREQ_LAT)) u_freq_line (
    .clk(clk), .rst_n(rst_n), .ev_in(freq_load), .pulse_n(freq_sync_n)
  );

  lsync_token_line #(.LAT(PHASE_LAT)) u_phase_line (
    .clk(clk), .rst_n(rst_n), .ev_in(phase_load), .pulse_n(phase_sync_n)
  );

  lsync_blank_window #(.EDGES(BLANK_EDGES)) u_blank (
    .clk(clk), .rst_n(rst_n), .ready(out_valid)
  );

  lsync_bank_toggle u_bank (
    .clk(clk), .rst_n(rst_n), .flip(freq_load), .bank(bank_sel)
  );
endmodule

// File: rtl/load_sync_tracker_chk.sv
module load_sync_tracker_chk #(
  parameter int unsigned FREQ_LAT    = 18,
  parameter int unsigned PHASE_LAT   = 11,
  parameter int unsigned BLANK_EDGES = 6
) (
  input logic clk,
  input logic rst_n,
  input logic freq_load,
  input logic phase_load,
  input logic freq_sync_n,
  input logic phase_sync_n,
  input logic out_valid,
  input logic bank_sel
);
  localparam int unsigned FPW = lsync_pkg::cnt_width(FREQ_LAT + 2);
  localparam int unsigned PPW = lsync_pkg::cnt_width(PHASE_LAT + 2);
  localparam int unsigned EW  = lsync_pkg::cnt_width(BLANK_EDGES);

  logic [FPW-1:0] f_owed;
  logic [PPW-1:0] p_owed;
  logic [EW-1:0]  edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_owed <= '0;
      p_owed <= '0;
      edges  <= '0;
    end else begin
      f_owed <= f_owed + FPW'(freq_load) - FPW'(!freq_sync_n);
      p_owed <= p_owed + PPW'(phase_load) - PPW'(!phase_sync_n);
      if (edges < EW'(BLANK_EDGES)) edges <= edges + 1'b1;
    end
  end

  assert_rst_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (freq_sync_n && phase_sync_n && !out_valid && !bank_sel));

  assert_fsync_owed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_sync_n |-> (f_owed != '0));

  assert_psync_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_sync_n |-> (p_owed != '0));

  assert_fowed_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    f_owed <= FPW'(FREQ_LAT + 1));

  assert_powed_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p_owed <= PPW'(PHASE_LAT + 1));

  assert_valid_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (edges >= EW'(BLANK_EDGES)));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  assert_bank_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_load |=> (bank_sel != $past(bank_sel)));

  assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_load |=> $stable(bank_sel));
endmodule

bind load_sync_tracker load_sync_tracker_chk #(
  .FREQ_LAT(FREQ_LAT), .PHASE_LAT(PHASE_LAT), .BLANK_EDGES(BLANK_EDGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freq_load(freq_load), .phase_load(phase_load),
  .freq_sync_n(freq_sync_n), .phase_sync_n(phase_sync_n),
  .out_valid(out_valid), .bank_sel(bank_sel)
);

// File: tb/load_sync_tracker_bench.sv
module load_sync_tracker_bench;
  localparam int FL = 18;
  localparam int PL = 11;
  localparam int NV = 4;
  localparam logic [63:0] FMASK [NV] = '{
    64'h0000_0000_0000_0004,   // lone frequency load
    64'h0000_0111_1111_1111,   // every fourth clock, ping-pong
    64'h0000_0000_0000_00E0,   // back-to-back
    64'h0000_0111_1111_1111    // every fourth, mixed with phase
  };
  localparam logic [63:0] PMASK [NV] = '{
    64'h0000_0000_0000_0008,
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_0060,
    64'h0000_0101_0101_0101    // every eighth clock
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic freq_load = 1'b0;
  logic phase_load = 1'b0;
  logic freq_sync_n, phase_sync_n, out_valid, bank_sel;

  int errors = 0;
  int checks = 0;
  logic exp_bank = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  load_sync_tracker u_load_sync_tracker (
    .clk(clk), .rst_n(rst_n), .freq_load(freq_load), .phase_load(phase_load),
    .freq_sync_n(freq_sync_n), .phase_sync_n(phase_sync_n),
    .out_valid(out_valid), .bank_sel(bank_sel)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive loads before an edge, then sample 5 ns after it
  task automatic step(input logic f, input logic p);
    @(negedge clk);
    freq_load  = f;
    phase_load = p;
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    @(negedge clk);
    freq_load = 1'b0;
    phase_load = 1'b0;
    rst_n = 1'b0;
    exp_bank = 1'b0;
    #5;
    chk("R1 freq_sync_n idle", freq_sync_n, 1'b1);
    chk("R1 phase_sync_n idle", phase_sync_n, 1'b1);
    chk("R1 out_valid low", out_valid, 1'b0);
    chk("R1 bank_sel low", bank_sel, 1'b0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    do_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 8; e++) begin
      @(posedge clk);
      #5;
      chk("R6 blank window", out_valid, (e >= 6));
    end

    // table of load schedules (R2 R3 R4 R5 R9)
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < 64; c++) begin
        step(FMASK[v][c], PMASK[v][c]);
        exp_bank = exp_bank ^ FMASK[v][c];
        chk("R2 R4 R5 freq pulse", freq_sync_n,
            !((c >= FL) && FMASK[v][(c >= FL) ? c - FL : 0]));
        chk("R3 R4 R5 phase pulse", phase_sync_n,
            !((c >= PL) && PMASK[v][(c >= PL) ? c - PL : 0]));
        chk("R9 bank select", bank_sel, exp_bank);
        chk("R6 valid held", out_valid, 1'b1);
      end
    end

    // R7: loads inside the blank window
    do_reset();
    for (int e = 1; e <= 24; e++) begin
      @(negedge clk);
      if (e == 1) rst_n = 1'b1;
      freq_load  = (e == 1);
      phase_load = (e == 1);
      @(posedge clk);
      #5;
      chk("R7 freq pulse in window", freq_sync_n, !(e == 1 + FL));
      chk("R7 phase pulse in window", phase_sync_n, !(e == 1 + PL));
      chk("R6 valid edge", out_valid, (e >= 6));
      chk("R9 bank after load", bank_sel, 1'b1);
    end

    // R8: reset while loads are in flight
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int e = 0; e < 4; e++) step(1'b0, 1'b0);
    do_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 24; e++) begin
      @(posedge clk);
      #5;
      chk("R8 no freq pulse", freq_sync_n, 1'b1);
      chk("R8 no phase pulse", phase_sync_n, 1'b1);
      chk("R8 bank cleared", bank_sel, 1'b0);
    end

    // R9: phase loads alone leave the bank select untouched
    for (int e = 0; e < 6; e++) begin
      step(1'b0, 1'b1);
      chk("R9 phase no flip", bank_sel, 1'b0);
    end
    step(1'b0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule